// File: doc/BRIEF.md
# Cartridge Bank Register Controller with Internal RAM Redirect

This block holds the bank registers that a CPU programs by writing into the upper half of its address space (0x8000 to 0xFFFF). Address bits 15..11 split that range into sixteen 2 KB write slots. Eight slots choose the page behind eight 1 KB pattern windows. Four slots choose the page behind four 1 KB nametable windows. Three slots set 8 KB program banks. The last slot is an auxiliary byte register. Downstream address multiplexers read the registered outputs directly.

A pattern or nametable value of 0xE0 or above does not name a ROM page. It redirects the window to internal RAM, and only the low bits of the value are kept as the RAM page. For the pattern windows this redirect can be switched off separately for each half: two flags, held in the second program-bank write, make large values act as plain ROM page numbers again. Every window is classified when it is written. A later change of a flag therefore leaves windows that are already mapped as they are. Two build-time parameters select board variants. One turns off nametable mapping entirely. The other picks how a bit of the first program-bank write drives the mirroring mode.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset every pattern and nametable window reads ROM page 0 (RAM flag 0), program windows 0..2 read bank 0, program window 3 reads PRG_BANKS-1 (63 by default), the auxiliary register reads 0, and the mirroring mode is the one a stored select bit of 0 gives (see R8).
- R2: A write to slot 0x8000 + 0x800*w (w = 0..7) with data below 0xE0 makes pattern window w a ROM window with page = data, visible on the clock edge that samples the strobe. No other pattern window changes.
- R3: With the half's disable flag clear, pattern data of 0xE0 or above selects RAM with page = data & 0x1F. 0xDF stays ROM page 0xDF and 0xE0 becomes RAM page 0.
- R4: A write to 0xE800 loads the disable flag for windows 0-3 from data bit 6 and the flag for windows 4-7 from data bit 7. While a window's flag is set, data of 0xE0 or above maps it to ROM page = data. A flag is used only when a window is written, so windows that are already mapped are not changed.
- R5: A write to slot 0xC000 + 0x800*n (n = 0..3) sets nametable window n. Data of 0xDF or below gives ROM page = data. Larger data gives RAM page = data & 1. The disable flags have no effect on these windows.
- R6: With NT_ROM_MAP = 0, writes to slots 0xC000 to 0xD800 leave every nametable output unchanged.
- R7: Writes to 0xE000, 0xE800 and 0xF000 set program windows 0, 1 and 2 from data bits 5..0. Program window 3 always reads PRG_BANKS-1.
- R8: mirror_mode encodes 0 = vertical, 1 = horizontal, 2 = single-screen low, 3 = fixed by board. With MIRROR_KIND = 1, bit 6 of the 0xE000 write selects vertical when set and single-screen low when clear. With MIRROR_KIND = 2, bit 7 selects horizontal when set and vertical when clear. With MIRROR_KIND = 0 the output is always 3.
- R9: The auxiliary register loads data only when the address is exactly 0xF800. Other addresses in 0xF800-0xFFFF leave it unchanged.
- R10: Cycles with wr_en low, and writes with address bit 15 clear, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| pat_is_ram | output | 8 | Per pattern window: 1 = internal RAM, 0 = ROM |
| pat_page | output | 64 | Pattern window w page in bits [8w+7:8w] |
| nt_is_ram | output | 4 | Per nametable window: 1 = internal RAM, 0 = ROM |
| nt_page | output | 32 | Nametable window n page in bits [8n+7:8n] |
| prg_win_bank | output | 4*PRG_W (24) | 8 KB program window k bank in bits [PRG_W*k+PRG_W-1:PRG_W*k] |
| mirror_mode | output | 2 | Mirroring mode, encoded as in R8 |
| aux_reg | output | 8 | Auxiliary register loaded at exactly 0xF800 |

## Verification
The hardest case to reach is a disable flag that changes between two pattern writes. The block must classify with the flag value at the moment of each write, and it must leave windows that are already mapped untouched. The stimulus maps windows in both halves with values of 0xE0 and above while the flags are clear. It then rewrites 0xE800 twice, once to set only the low-half flag and once to set only the high-half flag. After each rewrite it maps further windows in both halves. The scoreboard expects RAM in some windows and ROM in others, and it re-checks the windows written earlier. A second instance with the other board variant receives the same writes, so the ignored nametable writes and the other mirroring encoding are covered by the same sequence.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int PAT_WIN    = 8;
    localparam int HALF_WIN   = PAT_WIN / 2;
    localparam int NT_WIN     = 4;
    localparam int PRG_SLOTS  = 3;
    localparam logic [DATA_W-1:0] RAM_THRESH = 8'hE0;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_BOARD  = 2'd3
    } mirror_e;

    typedef struct packed {
        logic              is_ram;
        logic [DATA_W-1:0] page;
    } win_t;
endpackage

// File: rtl/cbm_slot_decode.sv
module cbm_slot_decode
    import cbm_pkg::*;
(
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    output logic [PAT_WIN-1:0]   pat_we,
    output logic [NT_WIN-1:0]    nt_we,
    output logic [PRG_SLOTS-1:0] prg_we,
    output logic                 aux_we
);
    logic [3:0] slot;

    always_comb begin
        slot   = wr_addr[14:11];
        pat_we = '0;
        nt_we  = '0;
        prg_we = '0;
        aux_we = 1'b0;
        if (wr_en && wr_addr[15]) begin
            if (!slot[3]) begin
                pat_we[slot[2:0]] = 1'b1;
            end else if (!slot[2]) begin
                nt_we[slot[1:0]] = 1'b1;
            end else if (slot != 4'hF) begin
                prg_we[slot[1:0]] = 1'b1;
            end else begin
                aux_we = (wr_addr[10:0] == 11'd0);
            end
        end
    end
endmodule

// File: rtl/cbm_win_classify.sv
module cbm_win_classify
    import cbm_pkg::*;
#(
    parameter logic [DATA_W-1:0] RAM_MASK = 8'h1F
) (
    input  logic [DATA_W-1:0] value,
    input  logic              ram_off,
    output win_t              win
);
    logic to_ram;

    always_comb begin
        to_ram     = (value >= RAM_THRESH) && !ram_off;
        win.is_ram = to_ram;
        win.page   = to_ram ? (value & RAM_MASK) : value;
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int PRG_BANKS   = 64,
    parameter bit NT_ROM_MAP  = 1'b1,
    parameter int MIRROR_KIND = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [15:0]             wr_addr,
    input  logic [7:0]              wr_data,
    output logic [7:0]              pat_is_ram,
    output logic [63:0]             pat_page,
    output logic [3:0]              nt_is_ram,
    output logic [31:0]             nt_page,
    output logic [4*$clog2(PRG_BANKS)-1:0] prg_win_bank,
    output logic [1:0]              mirror_mode,
    output logic [7:0]              aux_reg
);
    localparam int PRG_W   = $clog2(PRG_BANKS);
    localparam int MIR_BIT = (MIRROR_KIND == 2) ? 7 : 6;
    localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);

    typedef struct packed {
        win_t [PAT_WIN-1:0]                pat;
        win_t [NT_WIN-1:0]                 nt;
        logic [PRG_SLOTS-1:0][PRG_W-1:0]   prg;
        logic                              dis_lo;
        logic                              dis_hi;
        logic                              mir_sel;
        logic [DATA_W-1:0]                 aux;
    } state_t;

    state_t state_d, state_q;

    logic [PAT_WIN-1:0]   pat_we;
    logic [NT_WIN-1:0]    nt_we;
    logic [NT_WIN-1:0]    nt_we_eff;
    logic [PRG_SLOTS-1:0] prg_we;
    logic                 aux_we;
    win_t                 half_win [2];
    win_t                 nt_win;
    logic [1:0]           half_off;

    cbm_slot_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .pat_we  (pat_we),
        .nt_we   (nt_we),
        .prg_we  (prg_we),
        .aux_we  (aux_we)
    );

    assign half_off = {state_q.dis_hi, state_q.dis_lo};

    for (genvar h = 0; h < 2; h++) begin : g_half
        cbm_win_classify #(.RAM_MASK(8'h1F)) u_cls (
            .value   (wr_data),
            .ram_off (half_off[h]),
            .win     (half_win[h])
        );
    end

    cbm_win_classify #(.RAM_MASK(8'h01)) u_nt_cls (
        .value   (wr_data),
        .ram_off (1'b0),
        .win     (nt_win)
    );

    if (NT_ROM_MAP) begin : g_nt_on
        assign nt_we_eff = nt_we;
    end else begin : g_nt_off
        assign nt_we_eff = '0;
    end

    always_comb begin
        state_d = state_q;
        for (int h = 0; h < 2; h++) begin
            for (int k = 0; k < HALF_WIN; k++) begin
                if (pat_we[h*HALF_WIN + k]) begin
                    state_d.pat[h*HALF_WIN + k] = half_win[h];
                end
            end
        end
        for (int n = 0; n < NT_WIN; n++) begin
            if (nt_we_eff[n]) begin
                state_d.nt[n] = nt_win;
            end
        end
        for (int p = 0; p < PRG_SLOTS; p++) begin
            if (prg_we[p]) begin
                state_d.prg[p] = wr_data[PRG_W-1:0];
            end
        end
        if (prg_we[0]) begin
            state_d.mir_sel = wr_data[MIR_BIT];
        end
        if (prg_we[1]) begin
            state_d.dis_lo = wr_data[6];
            state_d.dis_hi = wr_data[7];
        end
        if (aux_we) begin
            state_d.aux = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar w = 0; w < PAT_WIN; w++) begin : g_pat_out
        assign pat_is_ram[w]        = state_q.pat[w].is_ram;
        assign pat_page[w*8 +: 8]   = state_q.pat[w].page;
    end

    for (genvar n = 0; n < NT_WIN; n++) begin : g_nt_out
        assign nt_is_ram[n]         = state_q.nt[n].is_ram;
        assign nt_page[n*8 +: 8]    = state_q.nt[n].page;
    end

    for (genvar p = 0; p < PRG_SLOTS; p++) begin : g_prg_out
        assign prg_win_bank[p*PRG_W +: PRG_W] = state_q.prg[p];
    end
    assign prg_win_bank[PRG_SLOTS*PRG_W +: PRG_W] = LAST_BANK;

    always_comb begin
        case (MIRROR_KIND)
            1:       mirror_mode = state_q.mir_sel ? MIR_VERT : MIR_ONE_LO;
            2:       mirror_mode = state_q.mir_sel ? MIR_HORZ : MIR_VERT;
            default: mirror_mode = MIR_BOARD;
        endcase
    end

    assign aux_reg = state_q.aux;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
    parameter bit NT_ROM_MAP = 1'b1,
    parameter int PRG_W      = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_addr,
    input logic [7:0]       wr_data,
    input logic [7:0]       pat_is_ram,
    input logic [63:0]      pat_page,
    input logic [3:0]       nt_is_ram,
    input logic [31:0]      nt_page,
    input logic [PRG_W-1:0] prg0,
    input logic [7:0]       aux_reg
);
    // R10: idle cycles leave all mapping state untouched
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pat_page) && $stable(pat_is_ram) && $stable(nt_page)
                   && $stable(nt_is_ram) && $stable(aux_reg));

    for (genvar w = 0; w < 8; w++) begin : g_pat
        // R2: ROM value lands in the addressed window one edge later
        a_r2_rom_page: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr[15:14] == 2'b10 && wr_addr[13:11] == w && wr_data < 8'hE0)
            |=> (!pat_is_ram[w] && pat_page[w*8 +: 8] == $past(wr_data)));
        // R2: windows not addressed keep their mapping
        a_r2_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !(wr_addr[15:14] == 2'b10 && wr_addr[13:11] == w))
            |=> ($stable(pat_page[w*8 +: 8]) && $stable(pat_is_ram[w])));
    end

    for (genvar n = 0; n < 4; n++) begin : g_nt
        if (NT_ROM_MAP) begin : g_on
            // R5: large nametable value selects RAM page bit 0
            a_r5_nt_ram: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr[15:11] == (5'b11000 | 5'(n)) && wr_data > 8'hDF)
                |=> (nt_is_ram[n] && nt_page[n*8 +: 8] == {7'd0, $past(wr_data[0])}));
        end else begin : g_off
            // R6: nametable writes ignored in this variant
            a_r6_nt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr[15:11] == (5'b11000 | 5'(n)))
                |=> ($stable(nt_is_ram[n]) && $stable(nt_page[n*8 +: 8])));
        end
    end

    // R7: first program window follows the 0xE000 write
    a_r7_prg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:11] == 5'b11100)
        |=> (prg0 == $past(wr_data[PRG_W-1:0])));

    // R9: auxiliary register only at the exact address
    a_r9_aux_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:11] == 5'b11111 && wr_addr[10:0] != 11'd0)
        |=> $stable(aux_reg));
endmodule

bind cart_bank_mapper cbm_checker #(
    .NT_ROM_MAP (NT_ROM_MAP),
    .PRG_W      (PRG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pat_is_ram (pat_is_ram),
    .pat_page   (pat_page),
    .nt_is_ram  (nt_is_ram),
    .nt_page    (nt_page),
    .prg0       (prg_win_bank[PRG_W-1:0]),
    .aux_reg    (aux_reg)
);

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;
    localparam int PW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;

    logic [7:0]  pat_is_ram, pat_is_ram2;
    logic [63:0] pat_page, pat_page2;
    logic [3:0]  nt_is_ram, nt_is_ram2;
    logic [31:0] nt_page, nt_page2;
    logic [4*PW-1:0] prg_win_bank, prg_win_bank2;
    logic [1:0]  mirror_mode, mirror_mode2;
    logic [7:0]  aux_reg, aux_reg2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cart_bank_mapper #(.PRG_BANKS(64), .NT_ROM_MAP(1'b1), .MIRROR_KIND(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pat_is_ram(pat_is_ram), .pat_page(pat_page), .nt_is_ram(nt_is_ram),
        .nt_page(nt_page), .prg_win_bank(prg_win_bank), .mirror_mode(mirror_mode),
        .aux_reg(aux_reg)
    );

    cart_bank_mapper #(.PRG_BANKS(64), .NT_ROM_MAP(1'b0), .MIRROR_KIND(2)) dut_v_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pat_is_ram(pat_is_ram2), .pat_page(pat_page2), .nt_is_ram(nt_is_ram2),
        .nt_page(nt_page2), .prg_win_bank(prg_win_bank2), .mirror_mode(mirror_mode2),
        .aux_reg(aux_reg2)
    );

    // observation selectors
    localparam int S_PPAGE = 0, S_PRAM = 1, S_NPAGE = 2, S_NRAM = 3, S_PRG = 4,
                   S_MIR = 5, S_AUX = 6, S_NPAGE2 = 7, S_NRAM2 = 8, S_MIR2 = 9;

    typedef struct {
        int    sel;
        int    idx;
        int    exp;
        string req;
    } exp_t;

    exp_t sb_q[$];

    function automatic int observe(int sel, int idx);
        case (sel)
            S_PPAGE:  return int'(pat_page[idx*8 +: 8]);
            S_PRAM:   return int'(pat_is_ram[idx]);
            S_NPAGE:  return int'(nt_page[idx*8 +: 8]);
            S_NRAM:   return int'(nt_is_ram[idx]);
            S_PRG:    return int'(prg_win_bank[idx*PW +: PW]);
            S_MIR:    return int'(mirror_mode);
            S_AUX:    return int'(aux_reg);
            S_NPAGE2: return int'(nt_page2[idx*8 +: 8]);
            S_NRAM2:  return int'(nt_is_ram2[idx]);
            S_MIR2:   return int'(mirror_mode2);
            default:  return -1;
        endcase
    endfunction

    task automatic expect_val(int sel, int idx, int exp, string req);
        exp_t it;
        it.sel = sel; it.idx = idx; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t it;
            int   got;
            it  = sb_q.pop_front();
            got = observe(it.sel, it.idx);
            n_checks++;
            if (got != it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d idx=%0d actual=0x%0h expected=0x%0h",
                         it.req, it.sel, it.idx, got, it.exp);
            end
        end
    end

    task automatic cpu_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
    endtask

    task automatic bus_no_strobe(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_addr = '0;
        wr_data = '0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        expect_val(S_PPAGE, 0, 0, "R1");
        expect_val(S_PRAM, 3, 0, "R1");
        expect_val(S_NPAGE, 2, 0, "R1");
        expect_val(S_PRG, 0, 0, "R1");
        expect_val(S_PRG, 3, 63, "R1");
        expect_val(S_AUX, 0, 0, "R1");
        expect_val(S_MIR, 0, 2, "R1");
        expect_val(S_MIR2, 0, 0, "R1");

        // R2 plain ROM mapping
        cpu_write(16'h8000, 8'h12);
        expect_val(S_PPAGE, 0, 8'h12, "R2");
        expect_val(S_PRAM, 0, 0, "R2");
        expect_val(S_PPAGE, 1, 0, "R2");
        cpu_write(16'hB800, 8'hDF);
        expect_val(S_PPAGE, 7, 8'hDF, "R3 boundary DF");
        expect_val(S_PRAM, 7, 0, "R3 boundary DF");

        // R3 RAM redirect
        cpu_write(16'h8800, 8'hE0);
        expect_val(S_PRAM, 1, 1, "R3");
        expect_val(S_PPAGE, 1, 0, "R3");
        cpu_write(16'hA000, 8'hFF);
        expect_val(S_PRAM, 4, 1, "R3");
        expect_val(S_PPAGE, 4, 8'h1F, "R3");

        // R4 low-half disable, no retro effect
        cpu_write(16'hE800, 8'h45);
        expect_val(S_PRG, 1, 5, "R7");
        expect_val(S_PRAM, 1, 1, "R4 no retro");
        cpu_write(16'h9000, 8'hE5);
        expect_val(S_PRAM, 2, 0, "R4 lo off");
        expect_val(S_PPAGE, 2, 8'hE5, "R4 lo off");
        cpu_write(16'hA800, 8'hE5);
        expect_val(S_PRAM, 5, 1, "R4 hi on");
        expect_val(S_PPAGE, 5, 8'h05, "R4 hi on");

        // R4 high-half disable
        cpu_write(16'hE800, 8'hBF);
        expect_val(S_PRG, 1, 8'h3F, "R7");
        expect_val(S_PRAM, 5, 1, "R4 no retro");
        cpu_write(16'hB000, 8'hF0);
        expect_val(S_PRAM, 6, 0, "R4 hi off");
        expect_val(S_PPAGE, 6, 8'hF0, "R4 hi off");
        cpu_write(16'h9800, 8'hF0);
        expect_val(S_PRAM, 3, 1, "R4 lo on");
        expect_val(S_PPAGE, 3, 8'h10, "R4 lo on");

        // R5 / R6 nametable windows
        cpu_write(16'hC000, 8'hDF);
        expect_val(S_NPAGE, 0, 8'hDF, "R5");
        expect_val(S_NRAM, 0, 0, "R5");
        expect_val(S_NPAGE2, 0, 0, "R6");
        cpu_write(16'hD800, 8'hE3);
        expect_val(S_NRAM, 3, 1, "R5 flags ignored");
        expect_val(S_NPAGE, 3, 1, "R5");
        expect_val(S_NRAM2, 3, 0, "R6");
        cpu_write(16'hC800, 8'hE2);
        expect_val(S_NRAM, 1, 1, "R5");
        expect_val(S_NPAGE, 1, 0, "R5");
        expect_val(S_NPAGE, 3, 1, "R5");

        // R7 / R8 program banks and mirroring
        cpu_write(16'hE000, 8'h6A);
        expect_val(S_PRG, 0, 8'h2A, "R7");
        expect_val(S_MIR, 0, 0, "R8 kind1 bit6=1");
        expect_val(S_MIR2, 0, 0, "R8 kind2 bit7=0");
        cpu_write(16'hE000, 8'h81);
        expect_val(S_PRG, 0, 1, "R7");
        expect_val(S_MIR, 0, 2, "R8 kind1 bit6=0");
        expect_val(S_MIR2, 0, 1, "R8 kind2 bit7=1");
        cpu_write(16'hF000, 8'hC7);
        expect_val(S_PRG, 2, 7, "R7");
        expect_val(S_PRG, 3, 63, "R7 fixed last");

        // R9 exact-address auxiliary register
        cpu_write(16'hF801, 8'h55);
        expect_val(S_AUX, 0, 0, "R9 F801");
        cpu_write(16'hFFFF, 8'h66);
        expect_val(S_AUX, 0, 0, "R9 FFFF");
        cpu_write(16'hF800, 8'h99);
        expect_val(S_AUX, 0, 8'h99, "R9");

        // R10 ignored writes
        cpu_write(16'h7800, 8'h33);
        expect_val(S_AUX, 0, 8'h99, "R10 low half");
        cpu_write(16'h0000, 8'h44);
        expect_val(S_PPAGE, 0, 8'h12, "R10 low half");
        bus_no_strobe(16'h8000, 8'h77);
        expect_val(S_PPAGE, 0, 8'h12, "R10 no strobe");
        bus_no_strobe(16'hE000, 8'h3C);
        expect_val(S_PRG, 0, 1, "R10 no strobe");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule